// File: doc/BRIEF.md
# Double-Banked Outer-Product Multiply-Accumulate Engine

This block updates a resident result tile Z (N rows by R columns) with the product of an operand tile X (N by M) and an operand tile Y (M by R), so that every element becomes z_ij + Σ_k x_ik·y_kj. It processes the update as a series of rank-one steps. For each inner index k, column k of X and row k of Y together touch every element of Z once. P identical multiply-add lanes each update one Z element per cycle, so one block occupies the lanes for M·N·R/P cycles.

Each operand has two storage banks. The host writes the next pair of tiles into the free bank while the lanes read from the other one. A start strobe commits the filled bank. When a block finishes issuing, its bank is released and the engine continues at once with the other bank if that bank is already committed. Each lane is a multiplier pipeline followed by one adder stage. The stored Z value is read in the same cycle the matching product leaves the multiplier. Because the elements are visited in a fixed rotation, two updates of the same element are always at least N·R/P cycles apart. Z persists across blocks until reset and is read through a combinational readout port.

Top module: `omac_engine`

## Requirements
- R1: After reset, done is low, ld_ready is high and every Z element reads zero.
- R2: A write with ld_valid high and ld_ready high goes to the bank currently being filled. With ld_src 0 it writes X element (i,k) at address i·M+k. With ld_src 1 it writes Y element (k,j) at address k·R+j. Addresses beyond the operand's size are dropped.
- R3: A start seen while ld_ready is high commits the bank being filled. Later writes go to the other bank, and the lanes never read the bank that is open for writing.
- R4: Each block adds X·Y into Z. Elements are two's-complement signed, DW bits wide, and Z elements are ZW-bit signed values. Successive blocks accumulate until reset.
- R5: The schedule uses k as the outer loop. Each k step spans N·R/P issue cycles, in which lane l handles element g·P+l of group g. done is a pulse exactly one cycle wide.
- R6: When the engine is idle, done rises at the (M·N·R/P + MUL_LAT + 1)-th rising edge after the edge that accepts start, and Z holds the block's result while done is high.
- R7: If the other bank is already committed when a block finishes issuing, the next block issues without a gap, and its done comes exactly M·N·R/P cycles after the previous done.
- R8: While both banks are committed, ld_ready is low, and writes and start strobes are ignored with no effect on Z or on the number of done pulses.
- R9: A Z element is never read for an update while its previous update is still in the adder stage. This requires N·R/P ≥ 2.
- R10: z_data shows Z element (i,j) combinationally for z_addr = i·R+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Operand write strobe |
| ld_src | input | 1 | 0 selects X, 1 selects Y |
| ld_addr | input | $clog2(max(N·M, M·R)) | Element address within the operand tile |
| ld_data | input | DW | Signed element value |
| ld_ready | output | 1 | The fill bank is free for writes and start |
| start | input | 1 | Commit the fill bank as the next block |
| done | output | 1 | One-cycle pulse when a block's last update is in Z |
| z_addr | input | $clog2(N·R) | Result element index i·R+j |
| z_data | output | ZW | Signed result element |

## Verification
The bench uses the default parameters: N=4, M=4, R=8, P=2, DW=8, ZW=20, MUL_LAT=2. With these values one block issues for 64 cycles but needs only 48 writes to load. A second block can therefore be written while the first is computing, and there is still time to try writes and a start while both banks are held. Full-range signed operands, including an all −128 tile, drive the sign extension and accumulation across three chained blocks. Group rotation over two lanes exercises the hazard spacing of 16 cycles.

// File: rtl/omac_pkg.sv
package omac_pkg;

  typedef enum logic {SRC_X = 1'b0, SRC_Y = 1'b1} ld_src_e;

  // element index of Z handled by lane l in issue group g
  function automatic int z_elem(input int g, input int l, input int lanes);
    return g * lanes + l;
  endfunction

  // slot of x(i,k) in an X tile with kdim columns
  function automatic int x_slot(input int i, input int k, input int kdim);
    return i * kdim + k;
  endfunction

  // slot of y(k,j) in a Y tile with cdim columns
  function automatic int y_slot(input int k, input int j, input int cdim);
    return k * cdim + j;
  endfunction

endpackage

// File: rtl/omac_banks.sv
module omac_banks #(
  parameter int N  = 4,
  parameter int M  = 4,
  parameter int R  = 8,
  parameter int P  = 2,
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int GW = 4,
  parameter int KW = 2
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 wr_src,
  input  logic                 wr_bank,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_bank,
  input  logic [KW-1:0]        rd_k,
  input  logic [GW-1:0]        rd_grp,
  output logic [P-1:0][DW-1:0] x_op,
  output logic [P-1:0][DW-1:0] y_op
);
  import omac_pkg::*;

  localparam int XD  = N * M;
  localparam int YD  = M * R;
  localparam int XAW = (XD > 1) ? $clog2(XD) : 1;
  localparam int YAW = (YD > 1) ? $clog2(YD) : 1;

  logic [DW-1:0] xmem [2][XD];
  logic [DW-1:0] ymem [2][YD];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_src == SRC_X) begin
        if (int'(wr_addr) < XD) xmem[wr_bank][XAW'(wr_addr)] <= wr_data;
      end else begin
        if (int'(wr_addr) < YD) ymem[wr_bank][YAW'(wr_addr)] <= wr_data;
      end
    end
  end

  for (genvar l = 0; l < P; l++) begin : g_rd
    always_comb begin
      int e, i, j;
      e = z_elem(int'(rd_grp), l, P);
      i = e / R;
      j = e % R;
      x_op[l] = xmem[rd_bank][XAW'(x_slot(i, int'(rd_k), M))];
      y_op[l] = ymem[rd_bank][YAW'(y_slot(int'(rd_k), j, R))];
    end
  end

endmodule

// File: rtl/omac_sched.sv
module omac_sched #(
  parameter int M    = 4,
  parameter int GRPS = 16,
  parameter int KW   = 2,
  parameter int GW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ld_ready,
  output logic          fill_bank,
  output logic          iss_valid,
  output logic          iss_bank,
  output logic [KW-1:0] iss_k,
  output logic [GW-1:0] iss_grp,
  output logic          iss_last
);
  logic       fill_q, cmp_q;
  logic [1:0] full_q, full_n;
  logic [KW-1:0] k_q;
  logic [GW-1:0] grp_q;
  logic       go, grp_wrap, k_wrap;

  assign ld_ready  = !full_q[fill_q];
  assign fill_bank = fill_q;
  assign go        = start && ld_ready;
  assign iss_valid = full_q[cmp_q];
  assign iss_bank  = cmp_q;
  assign iss_k     = k_q;
  assign iss_grp   = grp_q;
  assign grp_wrap  = (grp_q == GW'(GRPS - 1));
  assign k_wrap    = (k_q == KW'(M - 1));
  assign iss_last  = iss_valid && grp_wrap && k_wrap;

  always_comb begin
    full_n = full_q;
    if (go)       full_n[fill_q] = 1'b1;
    if (iss_last) full_n[cmp_q]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      cmp_q  <= 1'b0;
      full_q <= '0;
      k_q    <= '0;
      grp_q  <= '0;
    end else begin
      full_q <= full_n;
      if (go)       fill_q <= !fill_q;
      if (iss_last) cmp_q  <= !cmp_q;
      if (iss_valid) begin
        if (grp_wrap) begin
          grp_q <= '0;
          k_q   <= k_wrap ? '0 : k_q + 1'b1;
        end else begin
          grp_q <= grp_q + 1'b1;
        end
      end
    end
  end

  AST_BOTH_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q == 2'b11) |-> !ld_ready); // R8

endmodule

// File: rtl/omac_lane.sv
module omac_lane #(
  parameter int DW      = 8,
  parameter int ZW      = 20,
  parameter int MUL_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        op_a,
  input  logic [DW-1:0]        op_b,
  input  logic signed [ZW-1:0] addend,
  output logic signed [ZW-1:0] sum_q
);
  logic signed [2*DW-1:0] prod_pipe [MUL_LAT];
  logic signed [ZW-1:0]   prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MUL_LAT; s++) prod_pipe[s] <= '0;
    end else begin
      prod_pipe[0] <= $signed(op_a) * $signed(op_b);
      for (int s = 1; s < MUL_LAT; s++) prod_pipe[s] <= prod_pipe[s-1];
    end
  end

  assign prod_ext = ZW'(prod_pipe[MUL_LAT-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= addend + prod_ext;
  end

endmodule

// File: rtl/omac_engine.sv
module omac_engine #(
  parameter int N       = 4,
  parameter int M       = 4,
  parameter int R       = 8,
  parameter int P       = 2,
  parameter int DW      = 8,
  parameter int ZW      = 20,
  parameter int MUL_LAT = 2,
  localparam int ELEMS  = N * R,
  localparam int GRPS   = ELEMS / P,
  localparam int LDD    = (N * M > M * R) ? N * M : M * R,
  localparam int LDAW   = (LDD > 1) ? $clog2(LDD) : 1,
  localparam int ZAW    = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  input  logic           ld_src,
  input  logic [LDAW-1:0] ld_addr,
  input  logic [DW-1:0]  ld_data,
  output logic           ld_ready,
  input  logic           start,
  output logic           done,
  input  logic [ZAW-1:0] z_addr,
  output logic [ZW-1:0]  z_data
);
  import omac_pkg::*;

  localparam int KW = (M > 1) ? $clog2(M) : 1;
  localparam int GW = (GRPS > 1) ? $clog2(GRPS) : 1;

  // named internal events
  logic          fill_bank, iss_valid, iss_bank, iss_last;
  logic [KW-1:0] iss_k;
  logic [GW-1:0] iss_grp;
  logic [P-1:0][DW-1:0] x_op, y_op;

  logic          cp_valid [MUL_LAT];
  logic          cp_last  [MUL_LAT];
  logic [GW-1:0] cp_grp   [MUL_LAT];
  logic          rd_valid, rd_last, wb_valid, wb_last, done_q;
  logic [GW-1:0] rd_grp, wb_grp;

  logic signed [ZW-1:0] zmem [ELEMS];
  logic signed [ZW-1:0] z_add [P];
  logic signed [ZW-1:0] lane_sum [P];

  omac_sched #(.M(M), .GRPS(GRPS), .KW(KW), .GW(GW)) sched_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_ready(ld_ready),
    .fill_bank(fill_bank), .iss_valid(iss_valid), .iss_bank(iss_bank),
    .iss_k(iss_k), .iss_grp(iss_grp), .iss_last(iss_last)
  );

  omac_banks #(.N(N), .M(M), .R(R), .P(P), .DW(DW), .AW(LDAW), .GW(GW), .KW(KW)) banks_i (
    .clk(clk), .wr_en(ld_valid && ld_ready), .wr_src(ld_src), .wr_bank(fill_bank),
    .wr_addr(ld_addr), .wr_data(ld_data), .rd_bank(iss_bank), .rd_k(iss_k),
    .rd_grp(iss_grp), .x_op(x_op), .y_op(y_op)
  );

  // control pipe runs beside the lane multiplier pipes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MUL_LAT; s++) begin
        cp_valid[s] <= 1'b0;
        cp_last[s]  <= 1'b0;
        cp_grp[s]   <= '0;
      end
      wb_valid <= 1'b0;
      wb_last  <= 1'b0;
      wb_grp   <= '0;
      done_q   <= 1'b0;
    end else begin
      cp_valid[0] <= iss_valid;
      cp_last[0]  <= iss_last;
      cp_grp[0]   <= iss_grp;
      for (int s = 1; s < MUL_LAT; s++) begin
        cp_valid[s] <= cp_valid[s-1];
        cp_last[s]  <= cp_last[s-1];
        cp_grp[s]   <= cp_grp[s-1];
      end
      wb_valid <= rd_valid;
      wb_last  <= rd_valid && rd_last;
      wb_grp   <= rd_grp;
      done_q   <= wb_valid && wb_last;
    end
  end

  assign rd_valid = cp_valid[MUL_LAT-1];
  assign rd_last  = cp_last[MUL_LAT-1];
  assign rd_grp   = cp_grp[MUL_LAT-1];

  for (genvar l = 0; l < P; l++) begin : g_lane
    assign z_add[l] = zmem[ZAW'(z_elem(int'(rd_grp), l, P))];
    omac_lane #(.DW(DW), .ZW(ZW), .MUL_LAT(MUL_LAT)) lane_i (
      .clk(clk), .rst_n(rst_n), .op_a(x_op[l]), .op_b(y_op[l]),
      .addend(z_add[l]), .sum_q(lane_sum[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ELEMS; e++) zmem[e] <= '0;
    end else if (wb_valid) begin
      for (int l = 0; l < P; l++) zmem[ZAW'(z_elem(int'(wb_grp), l, P))] <= lane_sum[l];
    end
  end

  assign done   = done_q;
  assign z_data = zmem[z_addr];

  AST_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && wb_valid) |-> (rd_grp != wb_grp)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_FILL_NOT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready && iss_valid) |-> (fill_bank != iss_bank)); // R3
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wb_valid)); // R6

endmodule

// File: tb/omac_engine_tb.sv
`timescale 1ns/1ps
module omac_engine_tb_top;
  localparam int N = 4, M = 4, R = 8, P = 2, DW = 8, ZW = 20, ML = 2;
  localparam int XD = N * M, YD = M * R, ZE = N * R;
  localparam int BLK = M * N * R / P;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_src = 1'b0, start = 1'b0;
  logic [4:0] ld_addr = '0, z_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic ld_ready, done;
  logic [ZW-1:0] z_data;

  always #4 clk = !clk;

  omac_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_src(ld_src),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_ready(ld_ready), .start(start),
    .done(done), .z_addr(z_addr), .z_data(z_data)
  );

  int checks = 0, errors = 0, cyc = 0, ndone = 0, prev_done = 0;
  int done_at [16];
  int xa [4][XD];
  int ya [4][YD];
  int zref [ZE];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (ndone < 16) done_at[ndone] = cyc;
        ndone++;
        chk(prev_done == 0, "R5 done width", 2, 1);
      end
      prev_done = int'(done);
    end else prev_done = 0;
  end

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  // reference: sweep k outermost, fold one rank-one term at a time
  function automatic void ref_add(input int b);
    for (int k = 0; k < M; k++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < R; j++)
          zref[i*R+j] += xa[b][i*M+k] * ya[b][k*R+j];
  endfunction

  task automatic load_blk(input int b);
    for (int a = 0; a < XD + YD; a++) begin
      @(negedge clk);
      while (!ld_ready) @(negedge clk);
      ld_valid = 1'b1;
      ld_src   = (a >= XD);
      ld_addr  = 5'((a >= XD) ? a - XD : a);
      ld_data  = DW'((a >= XD) ? ya[b][a-XD] : xa[b][a]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_start(output int acc);
    while (!ld_ready) @(negedge clk);
    start = 1'b1;
    acc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_z(input string tag);
    for (int e = 0; e < ZE; e++) begin
      logic [ZW-1:0] ex;
      z_addr = 5'(e);
      #1;
      ex = ZW'(zref[e]);
      chk(z_data == ex, tag, int'($signed(z_data)), int'($signed(ex)));
    end
  endtask

  task automatic wait_dones(input int n);
    while (ndone < n) @(negedge clk);
  endtask

  initial begin
    int acc0, acc1, acc2, acc3, base;
    void'($urandom(32'd1234));
    for (int e = 0; e < XD; e++) begin
      xa[0][e] = rnd(-8, 7); xa[1][e] = rnd(-128, 127); xa[2][e] = -128; xa[3][e] = rnd(-20, 20);
    end
    for (int e = 0; e < YD; e++) begin
      ya[0][e] = rnd(-8, 7); ya[1][e] = rnd(-128, 127); ya[2][e] = -128;
      ya[3][e] = ((e / R) == (e % R)) ? 1 : 0; // R2 identity rows pin addressing
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_ready == 1'b1, "R1 ld_ready", int'(ld_ready), 1);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    for (int e = 0; e < ZE; e++) zref[e] = 0;
    check_z("R1 Z zero");

    load_blk(0); do_start(acc0);
    load_blk(1); do_start(acc1);
    // R8: both banks held, writes and start must be ignored
    for (int t = 0; t < 3; t++) begin
      chk(ld_ready == 1'b0, "R8 stall", int'(ld_ready), 0);
      ld_valid = 1'b1; ld_src = 1'b0; ld_addr = 5'(t); ld_data = 8'h7f; start = 1'b1;
      @(negedge clk);
    end
    ld_valid = 1'b0; start = 1'b0;
    load_blk(2); do_start(acc2);
    wait_dones(3);
    repeat (BLK + 20) @(negedge clk);
    chk(ndone == 3, "R8 no extra done", ndone, 3);
    chk(done_at[0] - acc0 == BLK + ML + 1, "R6 latency", done_at[0] - acc0, BLK + ML + 1);
    chk(done_at[1] - done_at[0] == BLK, "R7 back-to-back 1", done_at[1] - done_at[0], BLK);
    chk(done_at[2] - done_at[1] == BLK, "R7 back-to-back 2", done_at[2] - done_at[1], BLK);
    chk(acc2 < done_at[1], "R3 fill during compute", acc2, done_at[1]);
    for (int b = 0; b < 3; b++) ref_add(b);
    check_z("R4 R10 accumulated Z");

    // second run after reset: Z cleared, single block
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int e = 0; e < ZE; e++) zref[e] = 0;
    check_z("R1 Z after reset");
    base = ndone;
    load_blk(3); do_start(acc3);
    wait_dones(base + 1);
    chk(done_at[base] - acc3 == BLK + ML + 1, "R6 latency rerun", done_at[base] - acc3, BLK + ML + 1);
    ref_add(3);
    check_z("R2 R9 identity block");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule